// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This combinational unit decides where a 32-bit core fetches next. It takes the instruction word, the current PC and both register operands. For conditional branches it compares the operands and selects either the branch target or the sequential address. For jump-and-link and jump-and-link-register it produces the jump target, and it also produces a return address for the destination register, together with a write strobe.

It sits between decode and fetch in a simple pipeline. Any instruction that is not a control-flow instruction passes through as PC+4, with no link write. A conditional branch whose compare code is undefined is flagged on a separate output and is not taken.

Top module: `branch_next_pc`

## Requirements
- R1: For an opcode that is not 1100011, 1101111 or 1100111, and for opcode 1100111 with bits 14:12 other than 000, next PC is PC+4. In this case taken, link write and illegal are all 0.
- R2: With opcode 1100011, bits 14:12 = 000 take the branch when the operands are equal. Bits 14:12 = 001 take it when they differ.
- R3: With opcode 1100011, bits 14:12 = 100 take the branch when operand A is less than operand B as two's-complement values. Bits 14:12 = 101 take it when A is greater than or equal to B under the same signed compare.
- R4: With opcode 1100011, bits 14:12 = 110 take the branch when A is below B as unsigned values. Bits 14:12 = 111 take it when A is at or above B as unsigned values.
- R5: The branch offset is the sign-extended value {instr[31], instr[7], instr[30:25], instr[11:8], 0}. A taken branch gives PC plus this offset and raises taken. A branch that is not taken gives PC+4 with taken low.
- R6: With opcode 1100011 and bits 14:12 equal to 010 or 011, illegal is raised, the branch is not taken and next PC is PC+4.
- R7: Opcode 1101111 always gives next PC = PC plus the sign-extended offset {instr[31], instr[19:12], instr[20], instr[30:21], 0}, with taken high.
- R8: Opcode 1100111 with bits 14:12 = 000 gives next PC = (operand A + sign-extended instr[31:20]) with bit 0 cleared, with taken high.
- R9: For both jump forms the link value is PC+4 of the current PC. The link write is raised only when the destination field instr[11:7] is nonzero. Branches never raise the link write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| opa_i | input | 32 | First register operand (base for register jumps) |
| opb_i | input | 32 | Second register operand |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_we_o | output | 1 | Write the return address to the destination register |
| link_data_o | output | 32 | Return address (PC+4) |
| illegal_o | output | 1 | Undefined branch compare code |

## Verification
The bench puts operands where the signed and unsigned orderings disagree, such as all-ones against one. A design that swapped the two compare kinds would take exactly the wrong branches in that case. It uses the largest forward and backward branch and jump offsets, so a misplaced sign or a swapped bit in the scattered immediate fields moves the target visibly. An odd register-jump sum exposes a missing bit-0 clear. A zero destination field exposes a link write that should have been suppressed. The two undefined compare codes are driven with operands that would satisfy any compare, so a design that did not treat them as not-taken would branch.

// File: rtl/branch_next_pc.sv
module branch_next_pc #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_data_o,
  output logic            illegal_o
);
  localparam logic [6:0] OP_BR   = 7'b1100011;
  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;

  logic [6:0]      opc;
  logic [2:0]      f3;
  logic [XLEN-1:0] b_off, j_off, i_off, seq_pc, reg_tgt;
  logic            is_br, is_jal, is_jalr, cond, bad_f3;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];

  assign b_off = {{(XLEN-12){instr_i[31]}}, instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
  assign j_off = {{(XLEN-20){instr_i[31]}}, instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
  assign i_off = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};

  assign is_br   = (opc == OP_BR);
  assign is_jal  = (opc == OP_JAL);
  assign is_jalr = (opc == OP_JALR) && (f3 == 3'b000);

  always_comb begin
    cond   = 1'b0;
    bad_f3 = 1'b0;
    unique case (f3)
      3'b000: cond = (opa_i == opb_i);
      3'b001: cond = (opa_i != opb_i);
      3'b100: cond = ($signed(opa_i) <  $signed(opb_i));
      3'b101: cond = ($signed(opa_i) >= $signed(opb_i));
      3'b110: cond = (opa_i <  opb_i);
      3'b111: cond = (opa_i >= opb_i);
      default: bad_f3 = 1'b1;
    endcase
  end

  assign seq_pc  = pc_i + XLEN'(4);
  assign reg_tgt = (opa_i + i_off) & ~XLEN'(1);

  always_comb begin
    if (is_jal)               next_pc_o = pc_i + j_off;
    else if (is_jalr)         next_pc_o = reg_tgt;
    else if (is_br && cond)   next_pc_o = pc_i + b_off;
    else                      next_pc_o = seq_pc;
  end

  assign taken_o     = is_jal || is_jalr || (is_br && cond);
  assign illegal_o   = is_br && bad_f3;
  assign link_data_o = seq_pc;
  assign link_we_o   = (is_jal || is_jalr) && (instr_i[11:7] != 5'd0);
endmodule

module branch_next_pc_chk #(
  parameter int XLEN = 32
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic            illegal_o
);
  logic known;
  assign known = !$isunknown({instr_i, pc_i, next_pc_o, taken_o, link_we_o, illegal_o});

  always_comb begin
    if (known) begin
      // R5
      seq_when_not_taken_chk: assert (taken_o || next_pc_o == pc_i + XLEN'(4));
      // R6
      illegal_not_taken_chk: assert (!illegal_o || !taken_o);
      // R9
      link_only_jumps_chk: assert (!link_we_o ||
        ((instr_i[6:0] == 7'b1101111 || instr_i[6:0] == 7'b1100111) && instr_i[11:7] != 5'd0));
      // R9
      link_implies_taken_chk: assert (!link_we_o || taken_o);
      // R8
      reg_jump_even_chk: assert (!(instr_i[6:0] == 7'b1100111 && instr_i[14:12] == 3'b000) ||
        next_pc_o[0] == 1'b0);
      // R1
      other_op_quiet_chk: assert (instr_i[6:0] == 7'b1100011 || instr_i[6:0] == 7'b1101111 ||
        instr_i[6:0] == 7'b1100111 || (!taken_o && !link_we_o && !illegal_o));
    end
  end
endmodule

bind branch_next_pc branch_next_pc_chk #(.XLEN(XLEN)) chk (
  .instr_i(instr_i), .pc_i(pc_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
  .link_we_o(link_we_o), .illegal_o(illegal_o)
);

// File: tb/tb_branch_next_pc.sv
module tb_branch_next_pc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr, pc, opa, opb, next_pc, link_data;
  logic taken, link_we, illegal;

  branch_next_pc dut (
    .instr_i(instr), .pc_i(pc), .opa_i(opa), .opb_i(opb),
    .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
    .link_data_o(link_data), .illegal_o(illegal)
  );

  typedef struct {
    logic [31:0] nxt;
    logic        tk;
    logic        we;
    logic [31:0] ld;
    logic        il;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [2:0] f3);
    return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] off, input logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_r(input logic [11:0] imm, input logic [2:0] f3, input logic [4:0] rd);
    return {imm, 5'd1, f3, rd, 7'b1100111};
  endfunction

  task automatic drive(input logic [31:0] i, input logic [31:0] p, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] en, input logic et,
                       input logic ew, input logic ei, input string tag);
    exp_t e;
    @(posedge clk);
    instr = i; pc = p; opa = a; opb = b;
    e.nxt = en; e.tk = et; e.we = ew; e.ld = p + 32'd4; e.il = ei; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (next_pc !== e.nxt || taken !== e.tk || link_we !== e.we || illegal !== e.il ||
            (e.we && link_data !== e.ld)) begin
          errors++;
          $display("FAIL %s: got nxt=%h tk=%b we=%b ld=%h il=%b exp nxt=%h tk=%b we=%b ld=%h il=%b",
                   e.tag, next_pc, taken, link_we, link_data, illegal,
                   e.nxt, e.tk, e.we, e.ld, e.il);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] P = 32'h0000_1000;

  initial begin
    instr = 32'h0000_0013; pc = P; opa = 0; opb = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 plain arithmetic word, and an unrelated opcode
    drive(32'h0000_0013, P, 0, 0, P + 4, 0, 0, 0, "R1 addi");
    drive(32'h1234_50b7, P, 7, 7, P + 4, 0, 0, 0, "R1 lui");
    // R1 register jump with nonzero funct3 is not a jump
    drive(enc_r(12'h004, 3'b001, 5'd5), P, 32'h2000, 0, P + 4, 0, 0, 0, "R1 jalr f3");
    // R2 equal / not equal
    drive(enc_b(13'd16, 3'b000), P, 32'h55, 32'h55, P + 16, 1, 0, 0, "R2 beq taken");
    drive(enc_b(13'd16, 3'b000), P, 32'h55, 32'h56, P + 4, 0, 0, 0, "R2 beq not");
    drive(enc_b(-13'sd8, 3'b001), P, 1, 2, P - 8, 1, 0, 0, "R2 bne taken back");
    // R3 signed: -1 < 1
    drive(enc_b(13'h1000, 3'b100), P, 32'hFFFF_FFFF, 1, P - 32'd4096, 1, 0, 0, "R3 blt min off");
    drive(enc_b(13'd64, 3'b101), P, 32'hFFFF_FFFF, 1, P + 4, 0, 0, 0, "R3 bge not");
    drive(enc_b(13'd64, 3'b101), P, 5, 5, P + 64, 1, 0, 0, "R3 bge equal");
    // R4 unsigned: all-ones is large
    drive(enc_b(13'd32, 3'b110), P, 32'hFFFF_FFFF, 1, P + 4, 0, 0, 0, "R4 bltu not");
    drive(enc_b(13'd4094, 3'b111), P, 32'hFFFF_FFFF, 1, P + 4094, 1, 0, 0, "R4 bgeu max off");
    // R5 scattered offset bits: bit 11 and bit 1
    drive(enc_b(13'h0802, 3'b000), P, 0, 0, P + 32'h802, 1, 0, 0, "R5 offset bits");
    // R6 undefined compare codes
    drive(enc_b(13'd16, 3'b010), P, 3, 3, P + 4, 0, 0, 1, "R6 f3 010");
    drive(enc_b(13'd16, 3'b011), P, 0, 9, P + 4, 0, 0, 1, "R6 f3 011");
    // R7 jumps, R9 link
    drive(enc_j(21'h10_0000, 5'd1), P, 0, 0, P - 32'h10_0000, 1, 1, 0, "R7 jal min off");
    drive(enc_j(21'h0F_FFFE, 5'd0), P, 0, 0, P + 32'h0F_FFFE, 1, 0, 0, "R9 jal rd0");
    drive(enc_j(21'h00_0802, 5'd3), P, 0, 0, P + 32'h802, 1, 1, 0, "R7 jal bits");
    // R8 register jump, bit 0 cleared
    drive(enc_r(12'h004, 3'b000, 5'd5), P, 32'h2001, 0, 32'h2004, 1, 1, 0, "R8 jalr odd");
    drive(enc_r(12'hFFF, 3'b000, 5'd0), P, 32'h3000, 0, 32'h2FFE, 1, 0, 0, "R8 R9 jalr neg rd0");
    drive(enc_r(12'h7FF, 3'b000, 5'd31), 32'h8000_0000, 32'h10, 0, 32'h80E, 1, 1, 0, "R9 jalr link");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule